// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an eight-channel, ten-bit successive-approximation converter. It divides the input clock into a conversion tick. It turns a start request into a fixed-length conversion. During the conversion it presents trial codes to an external comparator and reads back that comparator's one-bit verdict. It stores each finished code in a per-channel result register, which can be read one byte at a time.

A start comes from the rising edge of a start-flag level or, when external triggering is enabled, from a falling edge of a trigger pin while the flag is high. Five channel orderings are supported: single conversion, repeated conversion, single sweep, looping sweep, and looping sweep with a priority channel interleaved. Precision (8 or 10 bits) and an optional sample-and-hold setting together fix the conversion length. In single conversion and single sweep, the block raises a done pulse when it finishes. In the same cycle it asks the owner of the start flag to clear the flag.

Top module: `sar_seq`

## Requirements
- R1: With external triggering disabled, the block starts a conversion (busy_o rises on the next edge) in the cycle where start_flag_i is 1, was 0 in the previous cycle, and vref_on_i is 1.
- R2: No conversion starts while vref_on_i is 0. Raising vref_on_i while start_flag_i is already high does not start one either.
- R3: One channel takes L conversion ticks. L is 59 for 10-bit without sample-and-hold, 49 for 8-bit without, 33 for 10-bit with, and 28 for 8-bit with.
- R4: clk_div_i selects ticks of every 1 (0), 2 (1) or 4 (2 or 3) input cycles, so one channel lasts L times that many cycles from the start edge.
- R5: In 10-bit mode a finished code is stored with bits 7:0 at byte address 2c and bits 9:8 in the low two bits of byte address 2c+1 (upper six bits read 0), for channel c. The code equals the largest value that the comparator accepts (cmp_i is 1 when input is at least trial_o). All result bytes read 0 after reset.
- R6: In 8-bit mode the code is the top eight trial bits (input divided by 4), written to byte 2c only. Byte 2c+1 keeps its old value.
- R7: mode_i 0 (single) converts chan_sel_i once. At the final edge, done_o and start_clr_o each pulse for one cycle as busy_o falls. mode_i values 5 to 7 act like 0.
- R8: mode_i 1 (repeat) converts chan_sel_i back to back until the start flag drops.
- R9: mode_i 2 (single sweep) converts channels 0 up to sweep_last_i in ascending order, then pulses done_o and start_clr_o.
- R10: mode_i 3 (looping sweep) converts 0 up to sweep_last_i, then wraps to 0, without stopping.
- R11: mode_i 4 (priority sweep) converts chan_sel_i between every other conversion: P,0,P,1,…,P,N,P,0,… where P is chan_sel_i and N is sweep_last_i.
- R12: With ext_trig_en_i set and start_flag_i high, a falling edge of trig_ni starts a conversion. Another falling edge during a conversion restarts it from its first channel and full length.
- R13: Dropping start_flag_i during a conversion stops it on the next edge with no done pulse. The result register being converted keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vref_on_i | input | 1 | Reference ladder connected; required for starts |
| start_flag_i | input | 1 | Start flag level |
| ext_trig_en_i | input | 1 | Select external trigger pin as start source |
| trig_ni | input | 1 | External trigger, active on falling edge |
| mode_i | input | 3 | Channel ordering mode |
| chan_sel_i | input | 3 | Selected channel, or priority channel in mode 4 |
| sweep_last_i | input | 3 | Highest channel of a sweep |
| res10_i | input | 1 | 1 = 10-bit, 0 = 8-bit |
| sh_en_i | input | 1 | Sample-and-hold timing |
| clk_div_i | input | 2 | Conversion tick divider select |
| cmp_i | input | 1 | Comparator verdict for trial_o |
| trial_o | output | 10 | Trial code to the ladder |
| ch_o | output | 3 | Channel routed to the comparator |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Single-pass completion pulse |
| start_clr_o | output | 1 | Request to clear the start flag |
| rd_addr_i | input | 4 | Result byte address |
| rd_data_o | output | 8 | Result byte |

## Verification
A wrong tick or trial count moves the falling edge of busy_o and the done pulse away from the start edge by at least one cycle. That error shows up on the first conversion in that precision, sample-and-hold and divider setting. A wrong channel pointer shows on ch_o in the very cycle it goes wrong, because ch_o is compared on every clock against an independent model of the mode's ordering. A fault in the trial register or in the byte packing appears as a wrong result byte when read back after the pass. A lost abort shows as busy_o staying high one cycle after the flag drops.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  parameter int NCH    = 8;
  parameter int CH_W   = $clog2(NCH);
  parameter int RES_W  = 10;
  parameter int LO_W   = 8;
  parameter int HI_W   = RES_W - LO_W;
  parameter int LEN_10 = 59;
  parameter int LEN_8  = 49;
  parameter int LEN_10_SH = 33;
  parameter int LEN_8_SH  = 28;
  parameter int CNT_W  = $clog2(LEN_10 + 1);

  typedef enum logic [2:0] {
    MODE_SINGLE  = 3'd0,
    MODE_REPEAT  = 3'd1,
    MODE_SWEEP   = 3'd2,
    MODE_LOOP    = 3'd3,
    MODE_PRIO    = 3'd4
  } mode_e;

  function automatic logic [CNT_W-1:0] conv_len(input logic res10, input logic sh);
    int l;
    if (sh) l = res10 ? LEN_10_SH : LEN_8_SH;
    else    l = res10 ? LEN_10 : LEN_8;
    return CNT_W'(l);
  endfunction
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic [1:0] div_sel_i,
  output logic       tick_o
);
  logic [1:0] divc_q, lim;

  always_comb begin
    case (div_sel_i)
      2'd0:    lim = 2'd0;
      2'd1:    lim = 2'd1;
      default: lim = 2'd3;
    endcase
  end

  assign tick_o = en_i && (divc_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      divc_q <= '0;
    else if (clear_i) divc_q <= '0;
    else if (en_i)    divc_q <= tick_o ? 2'd0 : divc_q + 2'd1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o && lim != 2'd0 && $stable(div_sel_i)) |=> !tick_o);
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             res10_i,
  input  logic             sh_en_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             last_o,
  output logic [RES_W-1:0] result_o
);
  logic [CNT_W-1:0] cnt_q, len, first_trial, k;
  logic [RES_W-1:0] sar_q, mask, sar_nx;
  logic             in_trial;

  assign len         = conv_len(res10_i, sh_en_i);
  assign first_trial = len - (res10_i ? CNT_W'(RES_W) : CNT_W'(LO_W));
  assign in_trial    = cnt_q >= first_trial;
  assign k           = cnt_q - first_trial;
  // MSB first, one bit per tick
  assign mask        = in_trial ? (RES_W'(1) << (RES_W - 1 - int'(k))) : '0;
  assign trial_o     = sar_q | mask;
  assign sar_nx      = cmp_i ? trial_o : sar_q;
  assign last_o      = cnt_q == len - CNT_W'(1);
  assign result_o    = sar_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sar_q <= '0;
    end else if (clear_i || (step_i && last_o)) begin
      cnt_q <= '0;
      sar_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      sar_q <= sar_nx;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && $stable(res10_i) && $stable(sh_en_i)) |=> (cnt_q < len));
endmodule

// File: rtl/sar_chan_order.sv
module sar_chan_order
  import sar_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            adv_i,
  input  mode_e           mode_i,
  input  logic [CH_W-1:0] sel_i,
  input  logic [CH_W-1:0] last_i,
  output logic [CH_W-1:0] ch_o,
  output logic            at_last_o
);
  logic [CH_W-1:0] ch_q, idx_q, idx_nx;
  logic            prio_turn_q;

  assign ch_o      = ch_q;
  assign at_last_o = ch_q == last_i;
  assign idx_nx    = (idx_q == last_i) ? '0 : idx_q + CH_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q        <= '0;
      idx_q       <= '0;
      prio_turn_q <= 1'b0;
    end else if (load_i) begin
      ch_q        <= (mode_i == MODE_SWEEP || mode_i == MODE_LOOP) ? '0 : sel_i;
      idx_q       <= '0;
      prio_turn_q <= 1'b1;
    end else if (adv_i) begin
      case (mode_i)
        MODE_SWEEP, MODE_LOOP: ch_q <= at_last_o ? '0 : ch_q + CH_W'(1);
        MODE_PRIO: begin
          if (prio_turn_q) begin
            ch_q        <= idx_q;
            prio_turn_q <= 1'b0;
          end else begin
            ch_q        <= sel_i;
            idx_q       <= idx_nx;
            prio_turn_q <= 1'b1;
          end
        end
        default: ch_q <= ch_q;
      endcase
    end
  end

  // R11
  prio_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && mode_i == MODE_PRIO && !prio_turn_q && $stable(sel_i)) |=> (ch_q == sel_i));
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank
  import sar_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CH_W-1:0]  wch_i,
  input  logic             res10_i,
  input  logic [RES_W-1:0] data_i,
  input  logic [CH_W:0]    rd_addr_i,
  output logic [LO_W-1:0]  rd_data_o
);
  logic [NCH-1:0][LO_W-1:0] lo_q;
  logic [NCH-1:0][HI_W-1:0] hi_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[c] <= '0;
        hi_q[c] <= '0;
      end else if (we_i && wch_i == CH_W'(c)) begin
        if (res10_i) begin
          lo_q[c] <= data_i[LO_W-1:0];
          hi_q[c] <= data_i[RES_W-1:LO_W];
        end else begin
          lo_q[c] <= data_i[RES_W-1:HI_W];
        end
      end
    end
  end

  assign rd_data_o = rd_addr_i[0] ? LO_W'(hi_q[rd_addr_i[CH_W:1]]) : lo_q[rd_addr_i[CH_W:1]];

  // R6
  hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && res10_i) |=> $stable(hi_q));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vref_on_i,
  input  logic             start_flag_i,
  input  logic             ext_trig_en_i,
  input  logic             trig_ni,
  input  logic [2:0]       mode_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic [CH_W-1:0]  sweep_last_i,
  input  logic             res10_i,
  input  logic             sh_en_i,
  input  logic [1:0]       clk_div_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             start_clr_o,
  input  logic [CH_W:0]    rd_addr_i,
  output logic [LO_W-1:0]  rd_data_o
);
  mode_e md;
  logic  busy_q, flag_q, trig_q, done_q;
  logic  start_ev, abort, tick, step, last, conv_end, finish, at_last, single_pass;
  logic [RES_W-1:0] result;

  assign md = mode_e'(mode_i);
  assign start_ev = vref_on_i && start_flag_i &&
                    (ext_trig_en_i ? (trig_q && !trig_ni) : !flag_q);
  assign abort    = busy_q && !start_flag_i;
  assign step     = busy_q && tick && !start_ev && !abort;
  assign conv_end = step && last;
  assign single_pass = !(md inside {MODE_REPEAT, MODE_SWEEP, MODE_LOOP, MODE_PRIO});
  assign finish   = conv_end && (single_pass || (md == MODE_SWEEP && at_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
      trig_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      flag_q <= start_flag_i;
      trig_q <= trig_ni;
      done_q <= finish;
      if (start_ev)              busy_q <= 1'b1;
      else if (abort || finish)  busy_q <= 1'b0;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign start_clr_o = done_q;

  sar_clkdiv u_div (
    .clk_i, .rst_ni, .clear_i(start_ev), .en_i(busy_q),
    .div_sel_i(clk_div_i), .tick_o(tick)
  );

  sar_bit_engine u_eng (
    .clk_i, .rst_ni, .clear_i(start_ev), .step_i(step), .res10_i, .sh_en_i,
    .cmp_i, .trial_o, .last_o(last), .result_o(result)
  );

  sar_chan_order u_ord (
    .clk_i, .rst_ni, .load_i(start_ev), .adv_i(conv_end && !finish), .mode_i(md),
    .sel_i(chan_sel_i), .last_i(sweep_last_i), .ch_o, .at_last_o(at_last)
  );

  sar_result_bank u_res (
    .clk_i, .rst_ni, .we_i(conv_end), .wch_i(ch_o), .res10_i, .data_i(result),
    .rd_addr_i, .rd_data_o
  );

  // R2
  no_start_wo_vref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vref_on_i && !busy_q) |=> !busy_q);
  // R13
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_flag_i) |=> (!busy_q && !done_q));
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  // R12
  retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_trig_en_i && start_flag_i && vref_on_i && trig_q && !trig_ni) |=> busy_q);
endmodule

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vref = 1'b0, flag = 1'b0, ext_en = 1'b0, trig = 1'b1;
  logic [2:0] mode = 3'd0, sel = 3'd0, last = 3'd0;
  logic       r10 = 1'b1, sh = 1'b0;
  logic [1:0] cdiv = 2'd0;
  logic       cmp;
  logic [9:0] trial;
  logic [2:0] ch;
  logic       busy, done, sclr;
  logic [3:0] raddr = 4'd0;
  logic [7:0] rdata;

  logic [9:0] vin [8] = '{10'h2A5, 10'h013, 10'h3FF, 10'h155, 10'h000, 10'h3C7, 10'h200, 10'h1FE};

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state
  int  m_busy = 0, m_done = 0, m_left = 0, m_ch = 0, m_pidx = 0, m_pturn = 0;
  int  m_flag_prev = 0, m_trig_prev = 1;
  int  exp_lo [8];
  int  exp_hi [8];

  always #4 clk = ~clk;

  assign cmp = vin[ch] >= trial;

  sar_seq u_sar_seq (
    .clk_i(clk), .rst_ni(rst_n), .vref_on_i(vref), .start_flag_i(flag),
    .ext_trig_en_i(ext_en), .trig_ni(trig), .mode_i(mode), .chan_sel_i(sel),
    .sweep_last_i(last), .res10_i(r10), .sh_en_i(sh), .clk_div_i(cdiv),
    .cmp_i(cmp), .trial_o(trial), .ch_o(ch), .busy_o(busy), .done_o(done),
    .start_clr_o(sclr), .rd_addr_i(raddr), .rd_data_o(rdata)
  );

  function automatic int ticks_per_ch();
    int l, d;
    if (sh) l = r10 ? 33 : 28; else l = r10 ? 59 : 49;
    d = (cdiv == 2'd0) ? 1 : (cdiv == 2'd1) ? 2 : 4;
    return l * d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_ch = 0; m_flag_prev = 0; m_trig_prev = 1;
      for (int i = 0; i < 8; i++) begin exp_lo[i] = 0; exp_hi[i] = 0; end
    end else begin
      bit st;
      m_done = 0;
      st = vref && flag && (ext_en ? (m_trig_prev == 1 && !trig) : (m_flag_prev == 0));
      if (st) begin
        m_busy = 1; m_left = ticks_per_ch(); m_pidx = 0; m_pturn = 1;
        m_ch = (mode == 3'd2 || mode == 3'd3) ? 0 : int'(sel);
      end else if (m_busy == 1 && !flag) begin
        m_busy = 0;
      end else if (m_busy == 1) begin
        m_left--;
        if (m_left == 0) begin
          if (r10) begin exp_lo[m_ch] = vin[m_ch] & 8'hFF; exp_hi[m_ch] = vin[m_ch] >> 8; end
          else exp_lo[m_ch] = vin[m_ch] >> 2;
          m_left = ticks_per_ch();
          case (mode)
            3'd1: ;
            3'd2: if (m_ch == int'(last)) begin m_busy = 0; m_done = 1; end else m_ch++;
            3'd3: m_ch = (m_ch == int'(last)) ? 0 : m_ch + 1;
            3'd4: if (m_pturn == 1) begin m_ch = m_pidx; m_pturn = 0; end
                  else begin m_pidx = (m_pidx == int'(last)) ? 0 : m_pidx + 1; m_ch = int'(sel); m_pturn = 1; end
            default: begin m_busy = 0; m_done = 1; end
          endcase
        end
      end
      m_flag_prev = flag;
      m_trig_prev = trig;
    end
  end

  // per-cycle comparison, and the start-flag register clearing
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      tests++;
      if (busy !== (m_busy == 1) || done !== (m_done == 1) || sclr !== (m_done == 1) ||
          (m_busy == 1 && int'(ch) != m_ch)) begin
        fails++;
        $display("FAIL %s cycle %0d: busy=%0b done=%0b clr=%0b ch=%0d expected busy=%0d done=%0d clr=%0d ch=%0d",
                 cur_req, cycles, busy, done, sclr, ch, m_busy, m_done, m_done, m_ch);
      end
      if (sclr) flag = 1'b0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] md, input logic [2:0] s, input logic [2:0] l,
                       input logic res, input logic shv, input logic [1:0] dv);
    @(negedge clk);
    mode = md; sel = s; last = l; r10 = res; sh = shv; cdiv = dv;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000 && (flag || busy); i++) @(negedge clk);
    idle(2);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) begin
      int e;
      @(negedge clk);
      raddr = 4'(a);
      #1;
      e = a[0] ? exp_hi[a/2] : exp_lo[a/2];
      tests++;
      if (int'(rdata) != e) begin
        fails++;
        $display("FAIL %s byte %0d: got %0h expected %0h", req, a, rdata, e);
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog expired, expected completion");
        summary();
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R5";
    read_all("R5 reset");

    // R2: no start without reference; late vref gives no edge
    cur_req = "R2";
    setup(3'd0, 3'd3, 3'd0, 1'b1, 1'b0, 2'd0);
    flag = 1'b1; idle(100);
    vref = 1'b1; idle(100);
    flag = 1'b0; idle(3);
    read_all("R2");

    // R1 R7 R5: single 10-bit conversion
    cur_req = "R7";
    setup(3'd0, 3'd3, 3'd0, 1'b1, 1'b0, 2'd0);
    flag = 1'b1; wait_end();
    read_all("R5");

    // R6: 10-bit then 8-bit on channel 5, upper byte kept
    cur_req = "R6";
    setup(3'd0, 3'd5, 3'd0, 1'b1, 1'b0, 2'd1);
    flag = 1'b1; wait_end();
    setup(3'd0, 3'd5, 3'd0, 1'b0, 1'b1, 2'd1);
    flag = 1'b1; wait_end();
    read_all("R6");

    // R3 R4: length across sample-and-hold, precision and divider
    cur_req = "R3";
    setup(3'd0, 3'd1, 3'd0, 1'b1, 1'b1, 2'd2);
    flag = 1'b1; wait_end();
    cur_req = "R4";
    setup(3'd6, 3'd0, 3'd0, 1'b0, 1'b0, 2'd3);
    flag = 1'b1; wait_end();
    read_all("R3");

    // R9: single sweep 0..3
    cur_req = "R9";
    setup(3'd2, 3'd0, 3'd3, 1'b1, 1'b1, 2'd0);
    flag = 1'b1; wait_end();
    read_all("R9");

    // R8: repeat channel 2 then abort
    cur_req = "R8";
    setup(3'd1, 3'd2, 3'd0, 1'b1, 1'b1, 2'd0);
    flag = 1'b1; idle(150);
    flag = 1'b0; idle(3);
    read_all("R8");

    // R13: abort before first result on channel 6
    cur_req = "R13";
    setup(3'd0, 3'd6, 3'd0, 1'b1, 1'b0, 2'd0);
    flag = 1'b1; idle(40);
    flag = 1'b0; idle(70);
    read_all("R13");

    // R10: looping sweep over 0..2 with wrap
    cur_req = "R10";
    setup(3'd3, 3'd0, 3'd2, 1'b0, 1'b1, 2'd0);
    flag = 1'b1; idle(28 * 7 + 10);
    flag = 1'b0; idle(3);
    read_all("R10");

    // R11: priority channel 7 interleaved with 0..2
    cur_req = "R11";
    setup(3'd4, 3'd7, 3'd2, 1'b1, 1'b1, 2'd0);
    flag = 1'b1; idle(33 * 9 + 5);
    flag = 1'b0; idle(3);
    read_all("R11");

    // R12: external falling edge starts, second edge restarts
    cur_req = "R12";
    setup(3'd0, 3'd4, 3'd0, 1'b1, 1'b0, 2'd0);
    ext_en = 1'b1; vin[4] = 10'h0F0;
    flag = 1'b1; idle(10);
    trig = 1'b0; idle(3); trig = 1'b1; idle(15);
    trig = 1'b0; idle(3); trig = 1'b1;
    wait_end();
    ext_en = 1'b0;
    read_all("R12");

    // R1: software start again after external mode
    cur_req = "R1";
    setup(3'd0, 3'd7, 3'd0, 1'b0, 1'b0, 2'd0);
    flag = 1'b1; wait_end();
    read_all("R1");

    summary();
  end
endmodule